// File: doc/BRIEF.md
# Interrupt Destination Resolver and Arbiter

This block takes one interrupt message and decides which of a parameterised set of processor-local interrupt agents receive it. A message carries an 8-bit destination, a 3-bit delivery mode, a physical/logical destination-mode bit, a 2-bit destination shorthand and the index of the sending agent. Each agent supplies four things: its 8-bit ID, its 8-bit logical destination register, its 8-bit arbitration priority, and a flag that says it already holds the message's vector pending or in service. A per-agent disable bit turns off that focus check.

The block resolves the addressing in one of three ways: physical, flat logical or shorthand. In lowest-priority delivery it then narrows the candidates to a single winner. A focus agent wins first. If there is none, the candidate with the smallest arbitration priority wins. The result is registered. It appears one clock after the request strobe as a selection bitmask, an accepted flag, a one-cycle send-accept error pulse when nobody was selected, and a one-cycle done pulse.

Top module: `irq_dest_arbiter`

## Requirements
- R1: With shorthand 0, physical mode (`req_logical`=0) and delivery mode 3'b001 (lowest priority), the message is dropped: mask 0, not accepted.
- R2: With shorthand 0, physical mode, a delivery mode other than 3'b001 and a destination of 8'hFF, every agent is selected.
- R3: With shorthand 0, physical mode and any other destination, only the lowest-index agent whose ID equals the destination is selected. If no ID matches, nothing is selected.
- R4: With shorthand 0 and logical mode (`req_logical`=1), a destination of 0 selects nobody. Otherwise every agent whose logical register ANDed with the destination is nonzero is a candidate, and all candidates are selected when the delivery mode is not 3'b001.
- R5: In lowest-priority arbitration, a candidate whose hold flag is 1 and whose focus-disable bit is 0 wins outright. Among several such candidates the lowest index wins. Exactly one agent is selected.
- R6: In lowest-priority arbitration with no focus candidate, the candidate with the numerically smallest arbitration priority wins. On a tie the lowest index wins.
- R7: Shorthand 1 selects only the sender, whatever the delivery mode. Shorthand 2 selects all agents. Shorthand 3 selects all agents except the sender.
- R8: With delivery mode 3'b001 and shorthand 2 or 3, arbitration runs over all agents, the sender included, and a single winner is selected.
- R9: `accepted` is 1 exactly when the selection mask is nonzero. `send_err` pulses for one cycle, with `done`, when a message is not accepted.
- R10: Results are registered. A request sampled at a clock edge shows its mask, `accepted` and a one-cycle `done` after that edge, and the mask and `accepted` hold until the next request. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per message |
| req_dest | input | 8 | Destination field |
| req_dmode | input | 3 | Delivery mode; 3'b001 = lowest priority |
| req_logical | input | 1 | 0 = physical, 1 = flat logical destination |
| req_short | input | 2 | Shorthand: 0 field, 1 self, 2 all, 3 all but self |
| req_sender | input | SEL_W | Index of the sending agent |
| agent_id | input | 8*N_AGENTS | Agent IDs, agent i at bits [8i+7:8i] |
| agent_ldr | input | 8*N_AGENTS | Logical destination registers |
| agent_prio | input | 8*N_AGENTS | Arbitration priorities |
| agent_hold | input | N_AGENTS | Agent holds the vector pending or in service |
| agent_focus_dis | input | N_AGENTS | Agent has focus checking disabled |
| sel_mask | output | N_AGENTS | Registered selection bitmask |
| accepted | output | 1 | Registered accept flag |
| send_err | output | 1 | One-cycle send-accept error pulse |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The assertions assume that `req_sender` is always a valid agent index below N_AGENTS. They also assume that the agent-side inputs stay stable from the strobe edge until the result is sampled, so that the registered mask belongs to the message that produced it. The bench drives every input on the falling clock edge and holds agent state constant across each request. It keeps the sender index within range and strobes `req_valid` for a single cycle, with idle cycles between messages, so no two results overlap.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  localparam int FIELD_W = 8;
  localparam logic [2:0] DM_LOWEST = 3'b001;
  localparam logic [FIELD_W-1:0] PHYS_ALL_ID = 8'hFF;

  typedef enum logic [1:0] {
    SH_FIELD    = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL      = 2'd2,
    SH_ALL_XSELF = 2'd3
  } shorthand_e;
endpackage

// File: rtl/irq_first_one.sv
module irq_first_one #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] vec_in,
  output logic [WIDTH-1:0] vec_out
);
  assign vec_out = vec_in & (~vec_in + WIDTH'(1));
endmodule

// File: rtl/irq_target_decode.sv
module irq_target_decode
  import irq_dest_pkg::*;
#(
  parameter int N_AGENTS = 4,
  localparam int SEL_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic [FIELD_W-1:0]          dest,
  input  logic [2:0]                  dmode,
  input  logic                        logical,
  input  logic [1:0]                  short_code,
  input  logic [SEL_W-1:0]            sender,
  input  logic [FIELD_W*N_AGENTS-1:0] ids,
  input  logic [FIELD_W*N_AGENTS-1:0] ldrs,
  output logic [N_AGENTS-1:0]         cand,
  output logic                        use_arb
);
  logic [N_AGENTS-1:0] id_hit;
  logic [N_AGENTS-1:0] id_first;
  logic [N_AGENTS-1:0] ldr_hit;
  logic [N_AGENTS-1:0] self_bit;
  logic                lowest;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_match
    assign id_hit[g]   = (ids[g*FIELD_W +: FIELD_W] == dest);
    assign ldr_hit[g]  = |(ldrs[g*FIELD_W +: FIELD_W] & dest);
    assign self_bit[g] = (sender == SEL_W'(g));
  end

  irq_first_one #(.WIDTH(N_AGENTS)) u_first (
    .vec_in  (id_hit),
    .vec_out (id_first)
  );

  assign lowest = (dmode == DM_LOWEST);

  always_comb begin
    cand    = '0;
    use_arb = 1'b0;
    unique case (shorthand_e'(short_code))
      SH_FIELD: begin
        if (!logical) begin
          if (!lowest) begin
            if (dest == PHYS_ALL_ID) cand = '1;
            else                     cand = id_first;
          end
        end else if (dest != '0) begin
          cand    = ldr_hit;
          use_arb = lowest;
        end
      end
      SH_SELF: cand = self_bit;
      SH_ALL: begin
        cand    = '1;
        use_arb = lowest;
      end
      SH_ALL_XSELF: begin
        cand    = lowest ? '1 : ~self_bit;
        use_arb = lowest;
      end
      default: cand = '0;
    endcase
  end
endmodule

// File: rtl/irq_lowpri_pick.sv
module irq_lowpri_pick
  import irq_dest_pkg::*;
#(
  parameter int N_AGENTS = 4
) (
  input  logic [N_AGENTS-1:0]         cand,
  input  logic [FIELD_W*N_AGENTS-1:0] prios,
  input  logic [N_AGENTS-1:0]         hold,
  input  logic [N_AGENTS-1:0]         focus_dis,
  output logic [N_AGENTS-1:0]         winner
);
  logic [N_AGENTS-1:0] focus_set;
  logic [N_AGENTS-1:0] focus_win;
  logic [N_AGENTS-1:0] prio_win;
  logic [FIELD_W-1:0]  best_prio;
  logic                have_best;

  assign focus_set = cand & hold & ~focus_dis;

  irq_first_one #(.WIDTH(N_AGENTS)) u_focus_first (
    .vec_in  (focus_set),
    .vec_out (focus_win)
  );

  always_comb begin
    prio_win  = '0;
    best_prio = '1;
    have_best = 1'b0;
    for (int i = 0; i < N_AGENTS; i++) begin
      if (cand[i] && (!have_best || prios[i*FIELD_W +: FIELD_W] < best_prio)) begin
        prio_win  = '0;
        prio_win[i] = 1'b1;
        best_prio = prios[i*FIELD_W +: FIELD_W];
        have_best = 1'b1;
      end
    end
  end

  assign winner = (|focus_set) ? focus_win : prio_win;
endmodule

// File: rtl/irq_dest_arbiter.sv
module irq_dest_arbiter
  import irq_dest_pkg::*;
#(
  parameter int N_AGENTS = 4,
  localparam int SEL_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [7:0]                  req_dest,
  input  logic [2:0]                  req_dmode,
  input  logic                        req_logical,
  input  logic [1:0]                  req_short,
  input  logic [SEL_W-1:0]            req_sender,
  input  logic [8*N_AGENTS-1:0]       agent_id,
  input  logic [8*N_AGENTS-1:0]       agent_ldr,
  input  logic [8*N_AGENTS-1:0]       agent_prio,
  input  logic [N_AGENTS-1:0]         agent_hold,
  input  logic [N_AGENTS-1:0]         agent_focus_dis,
  output logic [N_AGENTS-1:0]         sel_mask,
  output logic                        accepted,
  output logic                        send_err,
  output logic                        done
);
  logic [N_AGENTS-1:0] cand;
  logic [N_AGENTS-1:0] winner;
  logic [N_AGENTS-1:0] final_mask;
  logic                use_arb;

  irq_target_decode #(.N_AGENTS(N_AGENTS)) u_decode (
    .dest       (req_dest),
    .dmode      (req_dmode),
    .logical    (req_logical),
    .short_code (req_short),
    .sender     (req_sender),
    .ids        (agent_id),
    .ldrs       (agent_ldr),
    .cand       (cand),
    .use_arb    (use_arb)
  );

  irq_lowpri_pick #(.N_AGENTS(N_AGENTS)) u_pick (
    .cand      (cand),
    .prios     (agent_prio),
    .hold      (agent_hold),
    .focus_dis (agent_focus_dis),
    .winner    (winner)
  );

  assign final_mask = use_arb ? winner : cand;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_mask <= '0;
      accepted <= 1'b0;
      send_err <= 1'b0;
      done     <= 1'b0;
    end else begin
      done     <= req_valid;
      send_err <= req_valid && (final_mask == '0);
      if (req_valid) begin
        sel_mask <= final_mask;
        accepted <= |final_mask;
      end
    end
  end
endmodule

// File: rtl/irq_dest_arbiter_chk.sv
module irq_dest_arbiter_chk #(
  parameter int N_AGENTS = 4,
  localparam int SEL_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic [7:0]            req_dest,
  input logic [2:0]            req_dmode,
  input logic                  req_logical,
  input logic [1:0]            req_short,
  input logic [SEL_W-1:0]      req_sender,
  input logic [N_AGENTS-1:0]   sel_mask,
  input logic                  accepted,
  input logic                  send_err,
  input logic                  done
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done); // R10
  AST_DONE_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !done); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    send_err |-> (done && !accepted)); // R9
  AST_ACCEPT_MATCHES_MASK: assert property (@(posedge clk) disable iff (rst)
    done |-> (accepted == (sel_mask != '0))); // R9
  AST_PHYS_LOWEST_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_short == 2'd0 && !req_logical && req_dmode == 3'b001)
      |=> (sel_mask == '0 && send_err)); // R1
  AST_LOGICAL_ZERO_NOBODY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_short == 2'd0 && req_logical && req_dest == 8'h00)
      |=> (sel_mask == '0)); // R4
  AST_LOWEST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dmode == 3'b001 && req_short != 2'd1)
      |=> $onehot0(sel_mask)); // R5
  AST_BCAST_LOWEST_ONE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dmode == 3'b001 && req_short[1])
      |=> ($countones(sel_mask) == 1)); // R8
  AST_SELF_ONLY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_short == 2'd1)
      |=> (sel_mask == (N_AGENTS'(1) << $past(req_sender)))); // R7
  AST_BCAST_FIXED_ALL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_short == 2'd2 && req_dmode != 3'b001)
      |=> (sel_mask == '1)); // R7
endmodule

bind irq_dest_arbiter irq_dest_arbiter_chk #(.N_AGENTS(N_AGENTS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_dest    (req_dest),
  .req_dmode   (req_dmode),
  .req_logical (req_logical),
  .req_short   (req_short),
  .req_sender  (req_sender),
  .sel_mask    (sel_mask),
  .accepted    (accepted),
  .send_err    (send_err),
  .done        (done)
);

// File: tb/irq_dest_arbiter_tb.sv
module irq_dest_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [2:0] FIXED = 3'b000;
  localparam logic [2:0] LOWEST = 3'b001;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic [7:0]   req_dest;
  logic [2:0]   req_dmode;
  logic         req_logical;
  logic [1:0]   req_short;
  logic [1:0]   req_sender;
  logic [8*N-1:0] agent_id;
  logic [8*N-1:0] agent_ldr;
  logic [8*N-1:0] agent_prio;
  logic [N-1:0] agent_hold;
  logic [N-1:0] agent_focus_dis;
  logic [N-1:0] sel_mask;
  logic         accepted;
  logic         send_err;
  logic         done;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dest_arbiter #(.N_AGENTS(N)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dest(req_dest),
    .req_dmode(req_dmode), .req_logical(req_logical), .req_short(req_short),
    .req_sender(req_sender), .agent_id(agent_id), .agent_ldr(agent_ldr),
    .agent_prio(agent_prio), .agent_hold(agent_hold),
    .agent_focus_dis(agent_focus_dis), .sel_mask(sel_mask),
    .accepted(accepted), .send_err(send_err), .done(done)
  );

  task automatic check_val(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one message on a falling edge, check the registered result one
  // falling edge later (one rising edge in between).
  task automatic send_msg(input string tag, input logic [1:0] sh, input logic lg,
                          input logic [2:0] dm, input logic [7:0] dst,
                          input logic [1:0] snd, input logic [N-1:0] exp_mask);
    req_short = sh; req_logical = lg; req_dmode = dm; req_dest = dst;
    req_sender = snd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_val({tag, " mask"}, int'(sel_mask), int'(exp_mask));
    check_val({tag, " accepted (R9)"}, int'(accepted), int'(exp_mask != '0));
    check_val({tag, " send_err (R9)"}, int'(send_err), int'(exp_mask == '0));
    check_val({tag, " done (R10)"}, int'(done), 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check_val("R10 reset mask", int'(sel_mask), 0);
    check_val("R10 reset accepted", int'(accepted), 0);
    check_val("R10 reset send_err", int'(send_err), 0);
    check_val("R10 reset done", int'(done), 0);
  endtask

  task automatic t_physical();
    send_msg("R1 phys lowest dropped", 2'd0, 1'b0, LOWEST, 8'h10, 2'd0, 4'b0000);
    send_msg("R2 phys broadcast", 2'd0, 1'b0, FIXED, 8'hFF, 2'd0, 4'b1111);
    send_msg("R3 dup id lowest index", 2'd0, 1'b0, FIXED, 8'h11, 2'd0, 4'b0010);
    send_msg("R3 unique id", 2'd0, 1'b0, FIXED, 8'h12, 2'd0, 4'b0100);
    send_msg("R3 no id match", 2'd0, 1'b0, FIXED, 8'h55, 2'd0, 4'b0000);
  endtask

  task automatic t_logical();
    send_msg("R4 logical zero", 2'd0, 1'b1, FIXED, 8'h00, 2'd0, 4'b0000);
    send_msg("R4 logical multi", 2'd0, 1'b1, FIXED, 8'h06, 2'd0, 4'b1110);
    send_msg("R4 logical single", 2'd0, 1'b1, FIXED, 8'h01, 2'd0, 4'b0001);
    send_msg("R4 logical lowest zero", 2'd0, 1'b1, LOWEST, 8'h00, 2'd0, 4'b0000);
  endtask

  task automatic t_min_prio();
    send_msg("R6 tie lowest index", 2'd0, 1'b1, LOWEST, 8'h0F, 2'd0, 4'b0010);
    send_msg("R6 subset min", 2'd0, 1'b1, LOWEST, 8'h0C, 2'd0, 4'b0100);
  endtask

  task automatic t_focus();
    agent_hold = 4'b1000;
    send_msg("R5 focus beats prio", 2'd0, 1'b1, LOWEST, 8'h0F, 2'd0, 4'b1000);
    agent_hold = 4'b1100;
    send_msg("R5 two focus lowest index", 2'd0, 1'b1, LOWEST, 8'h0F, 2'd0, 4'b0100);
    agent_hold = 4'b1000; agent_focus_dis = 4'b1000;
    send_msg("R5 focus disabled", 2'd0, 1'b1, LOWEST, 8'h0F, 2'd0, 4'b0010);
    agent_hold = 4'b0001; agent_focus_dis = 4'b0000;
    send_msg("R5 focus not eligible", 2'd0, 1'b1, LOWEST, 8'h0C, 2'd0, 4'b0100);
    agent_hold = 4'b0000;
  endtask

  task automatic t_shorthand();
    send_msg("R7 self", 2'd1, 1'b0, FIXED, 8'h00, 2'd2, 4'b0100);
    send_msg("R7 self lowest", 2'd1, 1'b0, LOWEST, 8'h00, 2'd3, 4'b1000);
    send_msg("R7 all", 2'd2, 1'b0, FIXED, 8'h00, 2'd2, 4'b1111);
    send_msg("R7 all but self", 2'd3, 1'b0, FIXED, 8'h00, 2'd2, 4'b1011);
  endtask

  task automatic t_bcast_lowest();
    send_msg("R8 all lowest", 2'd2, 1'b0, LOWEST, 8'h00, 2'd0, 4'b0010);
    send_msg("R8 xself lowest incl sender", 2'd3, 1'b0, LOWEST, 8'h00, 2'd1, 4'b0010);
    agent_hold = 4'b1000;
    send_msg("R8 xself lowest focus", 2'd3, 1'b0, LOWEST, 8'h00, 2'd3, 4'b1000);
    agent_hold = 4'b0000;
  endtask

  task automatic t_hold_and_pulse();
    send_msg("R10 setup", 2'd0, 1'b0, FIXED, 8'h12, 2'd0, 4'b0100);
    check_val("R10 done one cycle", int'(done), 0);
    check_val("R10 err one cycle", int'(send_err), 0);
    check_val("R10 mask held", int'(sel_mask), 4'b0100);
    check_val("R10 accepted held", int'(accepted), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R10: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_dest = '0; req_dmode = '0;
    req_logical = 1'b0; req_short = '0; req_sender = '0;
    agent_id   = {8'h11, 8'h12, 8'h11, 8'h10};
    agent_ldr  = {8'h0C, 8'h04, 8'h02, 8'h01};
    agent_prio = {8'h30, 8'h20, 8'h20, 8'h40};
    agent_hold = '0; agent_focus_dis = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_physical();
    t_logical();
    t_min_prio();
    t_focus();
    t_shorthand();
    t_bcast_lowest();
    t_hold_and_pulse();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule